// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Sequencer

This block is the digital side of a three-wire serial port on a delta-sigma converter whose result is available with no latency. It moves through three states: converting, asleep and sending data. A host drives an active-low chip select and an external serial clock. The block drives a serial data line plus a separate output-enable, which stands for the tri-state control of the pad. A conversion timer counted in system clocks stands in for the modulator and the decimation filter. When the timer expires, a 30-bit result payload is captured from a parallel input. The payload is the sign, the extended-range flag, 24 result bits and 4 sub-LSB bits.

The first bit of each frame is also the end-of-conversion flag. A host that lowers chip select reads that line to poll for a finished conversion. It then clocks out the remaining 31 bits. The 32nd falling serial-clock edge starts the next conversion without any further command. Chip select, serial clock and the notch-select input arrive asynchronously. Each passes through a two-flop synchronizer, and serial-clock edges are detected in the system-clock domain. The result payload is sampled only at the end of a conversion and has no handshake, so no back-pressure applies to it. The host reads the result whenever it chooses, and the held frame waits for it indefinitely.

Top module: `dsadc_serial_seq`

## Requirements
- R1: After reset a conversion is running. While chip select is high the data line is not driven (`sdo_oe`=0, `sdo`=0). Lowering chip select during that first conversion makes `sdo` read 1.
- R2: With chip select low, `sdo` reads 1 for as long as a conversion runs and drops to 0 once it completes and the block is asleep.
- R3: A conversion lasts `CYC_SEL0` system clocks when `notch_sel` is 0 and `CYC_SEL1` when it is 1. At its end the frame payload is captured from `sample_word`.
- R4: The frame is 32 bits and is sent MSB first. Bit 31 is end-of-conversion (0 when a result is ready) and bit 30 is always 0. Bits 29..0 equal `sample_word[29:0]`: sign at 29, extended-range at 28, result at 27..4 and sub-LSB bits at 3..0.
- R5: During readout `sdo` moves to the next bit only on a falling serial-clock edge. A rising edge leaves `sdo` unchanged.
- R6: The 32nd falling serial-clock edge of a frame starts a new conversion, and `sdo` then reads 1.
- R7: While chip select is high the last result is held indefinitely. Raising chip select partway through a frame abandons it, and the next low chip select sends the same frame again from bit 31.
- R8: Serial-clock edges during a conversion, or while asleep with chip select high, have no effect on the frame that is read afterwards.
- R9: Changing `notch_sel` while asleep or during readout leaves the held frame unchanged. A change during a conversion affects only that conversion's length, and the next conversion runs the full length for the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sck | input | 1 | External serial clock (asynchronous) |
| notch_sel | input | 1 | Rejection-notch select, picks the conversion length (asynchronous) |
| sample_word | input | 30 | Result payload {sign, extended-range, 24-bit result, 4 sub-LSB bits} |
| sdo | output | 1 | Serial data out, forced 0 when not driven |
| sdo_oe | output | 1 | Output enable for the data pad, 0 means high-impedance |

## Verification
The bench times every conversion by counting the samples in which end-of-conversion is high, starting from the 32nd falling edge. A design that is off by one in its terminal count, or that latches the notch select at the wrong moment, returns the wrong length. After each rising serial-clock edge the bench re-samples the data line, which catches a design that shifts on the wrong edge. It toggles the serial clock during a conversion and while chip select is high, then reads a whole frame. A bit pointer that counts those stray edges shows up as misaligned bits. It also abandons a frame after ten bits and expects bit 31 again on the next low chip select. A design that resumes mid-frame or reloads the payload fails that check.

// File: rtl/dsadc_seq_pkg.sv
package dsadc_seq_pkg;
  localparam int PAYLOAD_W = 30;
  localparam int FRAME_W   = PAYLOAD_W + 2;
  localparam int PTR_W     = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } seq_state_e;

  // Status bit and dummy bit are both zero once a result is ready.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [PAYLOAD_W-1:0] p);
    return {1'b0, 1'b0, p};
  endfunction
endpackage

// File: rtl/dsadc_sync2.sv
module dsadc_sync2 #(
  parameter int             W    = 1,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= INIT[i];
        stable_q <= INIT[i];
      end else begin
        meta_q   <= d[i];
        stable_q <= meta_q;
      end
    end
    assign q[i] = stable_q;
  end
endmodule

// File: rtl/dsadc_conv_timer.sv
module dsadc_conv_timer #(
  parameter int CYC_SEL0 = 40,
  parameter int CYC_SEL1 = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel,
  output logic busy,
  output logic done
);
  localparam int CYC_MAX = (CYC_SEL0 > CYC_SEL1) ? CYC_SEL0 : CYC_SEL1;
  localparam int CW      = $clog2(CYC_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // Limit follows the live select, so a mid-run change only bends this run.
  assign limit = sel ? CW'(CYC_SEL1 - 1) : CW'(CYC_SEL0 - 1);
  assign done  = busy && !start && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsadc_frame_ptr.sv
module dsadc_frame_ptr
  import dsadc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic               rewind,
  input  logic               step,
  output logic               bit_out,
  output logic               at_last,
  output logic [PTR_W-1:0]   ptr,
  output logic [FRAME_W-1:0] frame_q
);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(FRAME_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      ptr     <= PTR_TOP;
    end else if (load) begin
      frame_q <= load_frame;
      ptr     <= PTR_TOP;
    end else if (rewind) begin
      ptr     <= PTR_TOP;
    end else if (step) begin
      ptr     <= at_last ? PTR_TOP : ptr - 1'b1;
    end
  end

  assign at_last = (ptr == '0);
  assign bit_out = frame_q[ptr];
endmodule

// File: rtl/dsadc_serial_seq.sv
module dsadc_serial_seq
  import dsadc_seq_pkg::*;
#(
  parameter int CYC_SEL0 = 40,
  parameter int CYC_SEL1 = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 notch_sel,
  input  logic [PAYLOAD_W-1:0] sample_word,
  output logic                 sdo,
  output logic                 sdo_oe
);
  logic [2:0]         pins_s;
  logic               cs_hi, sck_s, notch_s, sck_d;
  logic               sck_fall;
  seq_state_e         state, state_nx;
  logic               step, rewind, conv_start;
  logic               tim_busy, tim_done;
  logic               bit_out, at_last;
  logic [PTR_W-1:0]   ptr;
  logic [FRAME_W-1:0] frame_q;

  dsadc_sync2 #(.W(3), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sck, notch_sel}),
    .q(pins_s)
  );
  assign cs_hi   = pins_s[2];
  assign sck_s   = pins_s[1];
  assign notch_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign sck_fall = sck_d && !sck_s;

  assign step       = (state == ST_OUT) && !cs_hi && sck_fall;
  assign conv_start = step && at_last;
  assign rewind     = (state == ST_OUT) && cs_hi;

  dsadc_conv_timer #(.CYC_SEL0(CYC_SEL0), .CYC_SEL1(CYC_SEL1)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(conv_start), .sel(notch_s),
    .busy(tim_busy), .done(tim_done)
  );

  dsadc_frame_ptr u_frame (
    .clk(clk), .rst_n(rst_n),
    .load(tim_done), .load_frame(pack_frame(sample_word)),
    .rewind(rewind), .step(step),
    .bit_out(bit_out), .at_last(at_last),
    .ptr(ptr), .frame_q(frame_q)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_CONV:  if (tim_done)   state_nx = ST_SLEEP;
      ST_SLEEP: if (!cs_hi)     state_nx = ST_OUT;
      ST_OUT: begin
        if (cs_hi)           state_nx = ST_SLEEP;
        else if (conv_start) state_nx = ST_CONV;
      end
      default:               state_nx = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CONV;
    else        state <= state_nx;
  end

  assign sdo_oe = !cs_hi;
  assign sdo    = sdo_oe && ((state == ST_CONV) ? tim_busy : bit_out);
endmodule

// File: rtl/dsadc_serial_seq_chk.sv
module dsadc_serial_seq_chk
  import dsadc_seq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input seq_state_e         state,
  input logic               sdo,
  input logic               sdo_oe,
  input logic               cs_hi,
  input logic               sck_fall,
  input logic               at_last,
  input logic [PTR_W-1:0]   ptr,
  input logic [FRAME_W-1:0] frame_q
);
  // R2: converting with chip select low shows a high status bit
  a_r2_conv_status_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && sdo_oe) |-> sdo);

  // R2: asleep with chip select low shows a low status bit
  a_r2_sleep_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && sdo_oe) |-> !sdo);

  // R5: each counted falling edge moves exactly one bit down
  a_r5_one_bit_per_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && !cs_hi && sck_fall && !at_last) |=> (ptr == $past(ptr) - 1'b1));

  // R6: the last falling edge of a frame starts a conversion
  a_r6_restart_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && !cs_hi && sck_fall && at_last) |=> (state == ST_CONV));

  // R7: pad released while chip select is high
  a_r7_released_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |-> (!sdo_oe && !sdo));

  // R7: held frame never changes outside a conversion
  a_r7_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CONV) |=> $stable(frame_q));

  // R8: bit position only moves during readout
  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_OUT) |=> $stable(ptr));
endmodule

bind dsadc_serial_seq dsadc_serial_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .sdo(sdo), .sdo_oe(sdo_oe),
  .cs_hi(cs_hi), .sck_fall(sck_fall), .at_last(at_last), .ptr(ptr), .frame_q(frame_q)
);

// File: tb/dsadc_serial_seq_test.sv
module dsadc_serial_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CYC0 = 40;
  localparam int CYC1 = 48;
  localparam int NVEC = 6;
  // {notch_sel, sample_word}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 30'h2123_4567}, {1'b1, 30'h1FED_CBA9}, {1'b0, 30'h3FFF_FFFF},
    {1'b1, 30'h0000_0000}, {1'b0, 30'h2AAA_AAAA}, {1'b1, 30'h1555_5555}
  };
  localparam logic [29:0] W_A = 30'h0C0F_FEE1;
  localparam logic [29:0] W_B = 30'h3123_0ABC;
  localparam logic [29:0] W_C = 30'h1A5A_5A5A;
  localparam logic [29:0] W_D = 30'h2468_ACE0;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sck, notch_sel;
  logic [29:0] sample_word;
  logic        sdo, sdo_oe;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  dsadc_serial_seq #(.CYC_SEL0(CYC0), .CYC_SEL1(CYC1)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .notch_sel(notch_sel),
    .sample_word(sample_word), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (sdo === 1'b0) break;
    end
  endtask

  // Reads bits 31 down to 32-nbits; no falling edge after bit 0.
  task automatic read_part(input logic [29:0] w, input int nbits, input string req);
    logic [31:0] exp;
    exp = {2'b00, w};
    for (int b = 31; b >= 32 - nbits; b--) begin
      chk(sdo === exp[b] && sdo_oe === 1'b1, req, int'(sdo), int'(exp[b]));
      sck = 1'b1;
      settle();
      chk(sdo === exp[b], "R5 rising edge left data", int'(sdo), int'(exp[b]));
      if (b > 0) begin
        sck = 1'b0;
        settle();
      end
    end
  endtask

  // 32nd falling edge, then count samples with status high.
  task automatic last_fall_count(output int n);
    sck = 1'b0;
    @(negedge clk);
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (sdo === 1'b1) n++;
      else break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; notch_sel = 1'b0;
    sample_word = VEC[0][29:0];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R1 released after reset", int'({sdo_oe, sdo}), 0);
    cs_n = 1'b0;
    settle();
    chk(sdo === 1'b1, "R1 status high in first conversion", int'(sdo), 1);
    wait_done();
    chk(sdo === 1'b0, "R2 status low after conversion", int'(sdo), 0);

    // Vector walk: notch changes in sleep/readout, frame content, timing.
    for (int i = 0; i < NVEC; i++) begin
      notch_sel = VEC[i][30];
      settle();
      read_part(VEC[i][29:0], 32, "R4 R9 frame bit");
      sample_word = (i < NVEC - 1) ? VEC[i+1][29:0] : W_A;
      last_fall_count(n);
      chk(n == (VEC[i][30] ? CYC1 : CYC0), "R3 R6 conversion length", n, VEC[i][30] ? CYC1 : CYC0);
      chk(sdo === 1'b0, "R2 status low at end", int'(sdo), 0);
    end

    // R7: deselect, hold, stray clocks (R8), partial read and rewind.
    cs_n = 1'b1;
    settle();
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R7 released while deselected", int'({sdo_oe, sdo}), 0);
    repeat (300) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; settle();
      sck = 1'b0; settle();
    end
    cs_n = 1'b0;
    settle();
    read_part(W_A, 10, "R7 R8 held frame");
    cs_n = 1'b1;
    settle();
    cs_n = 1'b0;
    settle();
    notch_sel = 1'b0;
    read_part(W_A, 32, "R7 frame restarts at bit 31");

    // R8: clock edges during a conversion are ignored.
    sample_word = W_B;
    sck = 1'b0;
    settle();
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; settle();
      sck = 1'b0; settle();
    end
    wait_done();
    read_part(W_B, 32, "R8 frame after stray edges");

    // R9: notch change during a conversion only bends that conversion.
    sample_word = W_C;
    sck = 1'b0;
    repeat (15) @(negedge clk);
    notch_sel = 1'b1;
    wait_done();
    read_part(W_C, 32, "R3 payload captured at end");
    sample_word = W_D;
    last_fall_count(n);
    chk(n == CYC1, "R9 next conversion clean length", n, CYC1);
    read_part(W_D, 32, "R4 frame after notch change");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule